// File: doc/BRIEF.md
# Serial Link Flow Gate

This unit sits between a UART receiver and its transmitter and decides two things every cycle: whether the transmitter may start the next character, and whether a freshly received character is passed on to the receive data path. A 3-bit mode code selects the policy. The policies are no control, a clear-to-send input, in-band pause/resume characters, and two multidrop (addressed bus) variants. Two 8-bit character registers supply the codes it compares against. In the pause/resume policy they hold the resume and pause codes. In the multidrop policies they hold the address that opens the link and the address that closes it.

Received characters arrive as a 9-bit word with a valid strobe and a flag that marks 9-bit framing. Forwarded characters leave one cycle later, unchanged. The transmit permission is changed only while no character is being shifted out. A character that is already in flight always completes.

Top module: `fc_flow_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_allow_o` is 1 and `rx_valid_o` is 0. Pause state and link state both start cleared.
- R2: With mode code 0, 5, 6 or 7, every received character is forwarded and `tx_allow_o` stays 1. Characters equal to either register are forwarded too.
- R3: With mode code 1, when `tx_busy_i` is 0, `tx_allow_o` takes the value of `cts_i` sampled at the previous clock edge.
- R4: With mode code 2, a character whose bits [7:0] equal `stop_char_i` sets the pause, and one that equals `start_char_i` clears it. Either kind is consumed and not forwarded. `tx_allow_o` is the inverse of the pause, updated at the same edge that accepts the character. If both registers hold the same value, the pause wins.
- R5: With mode code 3, a character that arrives with `rx_nine_i`=1 and bit 8 set is an address and is never forwarded. If its bits [7:0] equal `start_char_i`, the link opens. If they equal `stop_char_i`, the link closes, and closing wins when both match. Any other address leaves the link unchanged. Other characters are forwarded only while the link is open. `tx_allow_o` stays 1.
- R6: With mode code 4, reception behaves as in R5, and `tx_allow_o` equals the link state, updated at the same edge as the link.
- R7: While `tx_busy_i` is 1, `tx_allow_o` does not change. A pending change takes effect at the first edge where `tx_busy_i` is 0.
- R8: The pause is cleared whenever the mode code is not 2. The link is closed whenever the mode code is neither 3 nor 4.
- R9: A forwarded character appears on `rx_data_o` with all 9 bits unchanged, one cycle after it is accepted, with `rx_valid_o` high for exactly one cycle.
- R10: In multidrop modes, a character received with `rx_nine_i`=0 is data whatever its bit 8 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Policy select code |
| start_char_i | input | 8 | Resume code or link-open address |
| stop_char_i | input | 8 | Pause code or link-close address |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 9 | Received character, bit 8 is the ninth bit |
| rx_nine_i | input | 1 | Character was framed with 9 data bits |
| cts_i | input | 1 | Clear-to-send level, 1 means send |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_allow_o | output | 1 | Transmitter may start a new character |
| rx_valid_o | output | 1 | Forwarded character strobe |
| rx_data_o | output | 9 | Forwarded character |

## Verification
The only hidden state is a pause bit, a link bit and the registered permission. A wrong value in any of them shows at the ports by the next cycle after a probe. A stuck pause shows as `tx_allow_o` low after a resume code. A stuck link shows as data dropped or leaked in multidrop modes, and the scoreboard catches it at the very next character. Mode switches are used to show that stale state is cleared. Runs of transmitter-busy cycles show that the permission is deferred and not lost.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_HW     = 3'd1,
        FC_SW     = 3'd2,
        FC_MD_RX  = 3'd3,
        FC_MD_ALL = 3'd4
    } fc_mode_e;

    typedef enum logic [2:0] {
        RC_DATA,
        RC_RESUME,
        RC_PAUSE,
        RC_ADDR_ON,
        RC_ADDR_OFF,
        RC_ADDR_MISS
    } rx_class_e;

    function automatic fc_mode_e fc_decode_mode(input logic [2:0] code);
        fc_mode_e m;
        case (code)
            3'd1:    m = FC_HW;
            3'd2:    m = FC_SW;
            3'd3:    m = FC_MD_RX;
            3'd4:    m = FC_MD_ALL;
            default: m = FC_NONE;
        endcase
        return m;
    endfunction

    function automatic logic fc_is_multidrop(input fc_mode_e m);
        return (m == FC_MD_RX) || (m == FC_MD_ALL);
    endfunction

endpackage

// File: rtl/fc_rx_classify.sv
module fc_rx_classify
    import fc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  fc_mode_e          mode,
    input  logic [CHAR_W-1:0] start_char,
    input  logic [CHAR_W-1:0] stop_char,
    input  logic [CHAR_W:0]   rx_data,
    input  logic              rx_nine,
    output rx_class_e         cls
);
    logic [CHAR_W-1:0] low_bits;
    logic              is_addr;
    logic              hit_start;
    logic              hit_stop;

    assign low_bits  = rx_data[CHAR_W-1:0];
    assign is_addr   = rx_nine && rx_data[CHAR_W];
    assign hit_start = (low_bits == start_char);
    assign hit_stop  = (low_bits == stop_char);

    always_comb begin
        cls = RC_DATA;
        case (mode)
            FC_SW: begin
                if (hit_stop)       cls = RC_PAUSE;
                else if (hit_start) cls = RC_RESUME;
            end
            FC_MD_RX, FC_MD_ALL: begin
                if (is_addr) begin
                    if (hit_stop)       cls = RC_ADDR_OFF;
                    else if (hit_start) cls = RC_ADDR_ON;
                    else                cls = RC_ADDR_MISS;
                end
            end
            default: cls = RC_DATA;
        endcase
    end
endmodule

// File: rtl/fc_link_state.sv
module fc_link_state
    import fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fc_mode_e  mode,
    input  logic      rx_valid,
    input  rx_class_e cls,
    output logic      paused_q,
    output logic      link_q,
    output logic      paused_d,
    output logic      link_d
);
    always_comb begin
        paused_d = paused_q;
        if (mode != FC_SW) begin
            paused_d = 1'b0;
        end else if (rx_valid) begin
            if (cls == RC_PAUSE)       paused_d = 1'b1;
            else if (cls == RC_RESUME) paused_d = 1'b0;
        end
    end

    always_comb begin
        link_d = link_q;
        if (!fc_is_multidrop(mode)) begin
            link_d = 1'b0;
        end else if (rx_valid) begin
            if (cls == RC_ADDR_OFF)      link_d = 1'b0;
            else if (cls == RC_ADDR_ON)  link_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            paused_q <= 1'b0;
            link_q   <= 1'b0;
        end else begin
            paused_q <= paused_d;
            link_q   <= link_d;
        end
    end

    // R8: leaving the software mode drops the pause
    a_r8_pause_cleared: assert property (@(posedge clk) disable iff (rst)
        (mode != FC_SW) |=> !paused_q);

    // R8: leaving the multidrop modes closes the link
    a_r8_link_closed: assert property (@(posedge clk) disable iff (rst)
        !fc_is_multidrop(mode) |=> !link_q);
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import fc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fc_mode_e mode,
    input  logic     cts,
    input  logic     tx_busy,
    input  logic     paused_d,
    input  logic     link_d,
    output logic     tx_allow
);
    logic permit_d;
    logic permit_q;

    always_comb begin
        case (mode)
            FC_HW:     permit_d = cts;
            FC_SW:     permit_d = !paused_d;
            FC_MD_ALL: permit_d = link_d;
            default:   permit_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           permit_q <= 1'b1;
        else if (!tx_busy) permit_q <= permit_d;
    end

    assign tx_allow = permit_q;

    // R7: no change while a character is on the wire
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        tx_busy |=> $stable(tx_allow));

    // R2 / R5: open policies always permit once idle
    a_r2_open_policy: assert property (@(posedge clk) disable iff (rst)
        ((mode == FC_NONE) || (mode == FC_MD_RX)) && !tx_busy |=> tx_allow);

    // R3: clear-to-send passes through with one edge
    a_r3_cts_follow: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_HW) && !tx_busy |=> (tx_allow == $past(cts)));
endmodule

// File: rtl/fc_flow_gate.sv
module fc_flow_gate
    import fc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    localparam int unsigned WORD_W = CHAR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [CHAR_W-1:0] start_char_i,
    input  logic [CHAR_W-1:0] stop_char_i,
    input  logic              rx_valid_i,
    input  logic [WORD_W-1:0] rx_data_i,
    input  logic              rx_nine_i,
    input  logic              cts_i,
    input  logic              tx_busy_i,
    output logic              tx_allow_o,
    output logic              rx_valid_o,
    output logic [WORD_W-1:0] rx_data_o
);
    fc_mode_e  mode;
    rx_class_e cls;
    logic      paused_q, link_q, paused_d, link_d;
    logic      forward;

    assign mode = fc_decode_mode(mode_i);

    fc_rx_classify #(.CHAR_W(CHAR_W)) classify_i (
        .mode       (mode),
        .start_char (start_char_i),
        .stop_char  (stop_char_i),
        .rx_data    (rx_data_i),
        .rx_nine    (rx_nine_i),
        .cls        (cls)
    );

    fc_link_state state_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .rx_valid (rx_valid_i),
        .cls      (cls),
        .paused_q (paused_q),
        .link_q   (link_q),
        .paused_d (paused_d),
        .link_d   (link_d)
    );

    fc_tx_gate gate_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cts      (cts_i),
        .tx_busy  (tx_busy_i),
        .paused_d (paused_d),
        .link_d   (link_d),
        .tx_allow (tx_allow_o)
    );

    assign forward = (cls == RC_DATA) && (!fc_is_multidrop(mode) || link_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= rx_valid_i && forward;
            if (rx_valid_i && forward) rx_data_o <= rx_data_i;
        end
    end

    // R1: reset leaves the transmitter free and nothing forwarded
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_allow_o && !rx_valid_o));

    // R5: address words never reach the receive path
    a_r5_addr_dropped: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i && fc_is_multidrop(mode) && rx_nine_i && rx_data_i[CHAR_W]
        |=> !rx_valid_o);

    // R4: pause and resume codes are consumed
    a_r4_ctrl_consumed: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i && (mode == FC_SW) &&
        ((rx_data_i[CHAR_W-1:0] == start_char_i) || (rx_data_i[CHAR_W-1:0] == stop_char_i))
        |=> !rx_valid_o);

    // R9: forwarded word is the accepted one
    a_r9_data_intact: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i && !(mode == FC_SW) && !fc_is_multidrop(mode)
        |=> (rx_valid_o && rx_data_o == $past(rx_data_i)));
endmodule

// File: tb/fc_flow_gate_tb_top.sv
module fc_flow_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode_i;
    logic [7:0] start_char_i, stop_char_i;
    logic       rx_valid_i;
    logic [8:0] rx_data_i;
    logic       rx_nine_i, cts_i, tx_busy_i;
    logic       tx_allow_o, rx_valid_o;
    logic [8:0] rx_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    fc_flow_gate dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .start_char_i(start_char_i), .stop_char_i(stop_char_i),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_nine_i(rx_nine_i),
        .cts_i(cts_i), .tx_busy_i(tx_busy_i),
        .tx_allow_o(tx_allow_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] d, input logic nine, input logic fwd, input string req);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = d;
        rx_nine_i  = nine;
        if (fwd) begin
            exp_q.push_back(d);
            tag_q.push_back(req);
        end
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_i = m;
        @(negedge clk);
    endtask

    // scoreboard monitor (R9 data integrity on every forwarded word)
    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9 unexpected word: actual %h expected none", rx_data_o);
            end else begin
                automatic string t = tag_q.pop_front();
                check(t, rx_data_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_i = 3'd0; start_char_i = 8'h11; stop_char_i = 8'h13;
        rx_valid_i = 1'b0; rx_data_i = '0; rx_nine_i = 1'b0; cts_i = 1'b1; tx_busy_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tx_allow", {8'd0, tx_allow_o}, 9'd1);
        check("R1 rx_valid", {8'd0, rx_valid_o}, 9'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {8'd0, tx_allow_o}, 9'd1);

        // R2: open policy forwards everything
        send(9'h041, 1'b0, 1'b1, "R2 plain");
        send(9'h013, 1'b0, 1'b1, "R2 stop code passes");
        check("R2 tx_allow mode0", {8'd0, tx_allow_o}, 9'd1);
        set_mode(3'd6);
        send(9'h011, 1'b0, 1'b1, "R2 mode6 start code passes");
        send(9'h1AB, 1'b1, 1'b1, "R2 mode6 nine-bit word");
        check("R2 tx_allow mode6", {8'd0, tx_allow_o}, 9'd1);

        // R3: clear-to-send
        set_mode(3'd1);
        check("R3 cts high", {8'd0, tx_allow_o}, 9'd1);
        @(negedge clk); cts_i = 1'b0;
        @(negedge clk);
        check("R3 cts low", {8'd0, tx_allow_o}, 9'd0);
        send(9'h033, 1'b0, 1'b1, "R3 rx unaffected");
        @(negedge clk); cts_i = 1'b1;
        @(negedge clk);
        check("R3 cts back", {8'd0, tx_allow_o}, 9'd1);

        // R4: pause/resume codes
        set_mode(3'd2);
        send(9'h055, 1'b0, 1'b1, "R4 data passes");
        send(9'h013, 1'b0, 1'b0, "R4 pause");
        check("R4 paused", {8'd0, tx_allow_o}, 9'd0);
        send(9'h056, 1'b0, 1'b1, "R4 data while paused");
        send(9'h011, 1'b0, 1'b0, "R4 resume");
        check("R4 resumed", {8'd0, tx_allow_o}, 9'd1);
        @(negedge clk); start_char_i = 8'h22; stop_char_i = 8'h22;
        send(9'h022, 1'b0, 1'b0, "R4 equal codes");
        check("R4 equal codes pause wins", {8'd0, tx_allow_o}, 9'd0);
        @(negedge clk); start_char_i = 8'h11; stop_char_i = 8'h13;
        send(9'h011, 1'b0, 1'b0, "R4 resume");
        check("R4 resumed again", {8'd0, tx_allow_o}, 9'd1);

        // R7: deferred while busy
        @(negedge clk); tx_busy_i = 1'b1;
        send(9'h013, 1'b0, 1'b0, "R7 pause during busy");
        check("R7 held while busy", {8'd0, tx_allow_o}, 9'd1);
        @(negedge clk);
        check("R7 still held", {8'd0, tx_allow_o}, 9'd1);
        tx_busy_i = 1'b0;
        @(negedge clk);
        check("R7 applied after busy", {8'd0, tx_allow_o}, 9'd0);

        // R8: mode switch clears the pause
        set_mode(3'd0);
        check("R8 open after leaving", {8'd0, tx_allow_o}, 9'd1);
        set_mode(3'd2);
        check("R8 pause cleared", {8'd0, tx_allow_o}, 9'd1);

        // R5: multidrop, receive side only
        set_mode(3'd3);
        send(9'h077, 1'b1, 1'b0, "R5 data before address");
        send(9'h111, 1'b1, 1'b0, "R5 open address");
        send(9'h077, 1'b1, 1'b1, "R5 data after open");
        send(9'h1AA, 1'b1, 1'b0, "R5 other address");
        send(9'h078, 1'b1, 1'b1, "R5 link kept");
        check("R5 tx free", {8'd0, tx_allow_o}, 9'd1);
        send(9'h113, 0, 1'b1, "R10 bit8 without nine flag is data");
        send(9'h005, 1'b0, 1'b1, "R10 link still open");
        send(9'h113, 1'b1, 1'b0, "R5 close address");
        send(9'h079, 1'b1, 1'b0, "R5 data after close");

        // R6: multidrop, both directions
        set_mode(3'd0);
        set_mode(3'd4);
        check("R6 closed on entry", {8'd0, tx_allow_o}, 9'd0);
        send(9'h111, 1'b1, 1'b0, "R6 open address");
        check("R6 tx opens", {8'd0, tx_allow_o}, 9'd1);
        send(9'h0C3, 1'b1, 1'b1, "R6 data");
        send(9'h113, 1'b1, 1'b0, "R6 close address");
        check("R6 tx closes", {8'd0, tx_allow_o}, 9'd0);
        send(9'h111, 1'b1, 1'b0, "R6 reopen");
        @(negedge clk); start_char_i = 8'h22; stop_char_i = 8'h22;
        send(9'h122, 1'b1, 1'b0, "R6 equal addresses");
        check("R6 close wins", {8'd0, tx_allow_o}, 9'd0);

        repeat (3) @(negedge clk);
        check("R9 queue drained", 9'(exp_q.size()), 9'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule